// File: doc/BRIEF.md
# LED Selector Open-Drain Pin Resolver

This block holds the pin logic of a sixteen-pin LED driver behind a simple synchronous register port. Each pin has a 2-bit selector code held in one of four selector registers. The code either pulls the pin to ground (LED lit) or lets it float so that a pull-up raises it (LED dark). Two further codes select a blink generator, which lies outside this block. An active-low external input for each pin can pull a floating pin down. The level seen on the pin is therefore the wired-AND of the block's own drive and the external pull.

Each pin's resolved level is held by a two-state machine with states `LVL_LOW` and `LVL_HIGH`. It moves to `LVL_LOW` when the selector drives the pin low, or when the pin is released and the external input is low. It moves to `LVL_HIGH` when the pin is released and the external input is high. On either blink code it takes a self-loop and keeps its state. The state vector is read back through two read-only level registers. It also appears directly on a level output, and a one-cycle strobe marks every real change of level.

Register access goes through a pointer. Every access, read or write, loads the pointer with its address. A write also updates the addressed selector register. The read data always shows the register the pointer names. Address map: level registers at 0x00 (pins 0 to 7) and 0x01 (pins 8 to 15); selector registers at 0x04 to 0x07. Every other address is unmapped.

Top module: `led_pin_resolver`

## Requirements
- R1: After reset, all four selector registers read 0x55 and both level registers read 0xFF. `lvl_out` is 0xFFFF, `chg_strb` is 0, and `rd_data` is 0x00 because the pointer resets to 0xFF, which is unmapped.
- R2: Selector code 00 makes the pin's level 0 whatever its external input does, so a change of that input causes no level change and no strobe.
- R3: Selector code 01 makes the pin's level equal its `ext_n` bit: 1 (floating, pulled up) reads 1, and 0 (pulled down) reads 0.
- R4: Selector register k (address 0x04+k) bits [2j+1:2j] hold the code of pin 4k+j. The level of pin i is at bit (i mod 8) of level register i/8 (address 0x00 or 0x01). Writing 0x54 to 0x04 makes 0x00 read 0xFE, and writing 0x54 to 0x07 makes 0x01 read 0xEF.
- R5: Selector codes 10 and 11 leave the pin's level at its previous value, even when its external input changes.
- R6: `chg_strb[i]` is high for exactly one cycle, in the cycle in which `lvl_out[i]` takes a new value, and stays low when a re-evaluation gives the same level.
- R7: A change of `ext_n` shows on the levels at the next clock edge. A selector write takes effect in the register at its own edge, and the levels follow at the edge after that, so they are unchanged in the cycle after the write edge.
- R8: Writes to the level registers and to unmapped addresses change no state, and reads of unmapped addresses return 0x00.
- R9: Every access (`acc_valid` high) loads the pointer with `acc_addr`. `rd_data` shows the register named by the pointer from the cycle after that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = pointer-only read access |
| acc_addr | input | 8 | Register address |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Contents of the register named by the pointer |
| ext_n | input | 16 | External pull per pin, 0 pulls the pin low |
| lvl_out | output | 16 | Resolved level per pin |
| chg_strb | output | 16 | One-cycle strobe per pin on a level change |

## Verification
A pin machine in the wrong state shows on `lvl_out` and in its level register at once, and it stays wrong until the pin is next forced by code 00 or 01. A wrong blink-mode hold therefore shows only while a blink code is selected, and the sweep checks it from both prior levels. A missing or spurious strobe is visible only in the cycle of the update edge, so the bench samples `chg_strb` in that cycle and in no other. A selector bit landing in the wrong field moves the low level to another pin, and this shows in the very first cycle after the update edge.

// File: rtl/led_pin_pkg.sv
package led_pin_pkg;

    typedef enum logic [1:0] {
        SEL_DRIVE_LOW = 2'b00,
        SEL_RELEASE   = 2'b01,
        SEL_BLINK_A   = 2'b10,
        SEL_BLINK_B   = 2'b11
    } sel_mode_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } pin_lvl_e;

    localparam logic [7:0] PTR_RESET_VAL = 8'hFF;
    localparam logic [7:0] SEL_RESET_VAL = 8'h55;

endpackage

// File: rtl/led_sel_regs.sv
module led_sel_regs
    import led_pin_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [DATA_W-1:0]     acc_wdata,
    input  logic [NUM_PINS-1:0]   lvl_bits,
    output logic [2*NUM_PINS-1:0] sel_flat,
    output logic [DATA_W-1:0]     rd_data
);

    localparam int N_IN     = NUM_PINS / DATA_W;
    localparam int N_SEL    = 2 * NUM_PINS / DATA_W;
    localparam int SEL_BASE = 2 * N_IN;

    logic [ADDR_W-1:0] ptr_q;

    // pointer register: loaded by every access
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= ADDR_W'(PTR_RESET_VAL);
        else if (acc_valid) ptr_q <= acc_addr;
    end

    p_ptr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (ptr_q == $past(acc_addr)));

    logic [DATA_W-1:0] sel_q [N_SEL];

    for (genvar k = 0; k < N_SEL; k++) begin : g_sel
        always_ff @(posedge clk) begin
            if (!rst_n) sel_q[k] <= DATA_W'(SEL_RESET_VAL);
            else if (acc_valid && acc_write && (acc_addr == ADDR_W'(SEL_BASE + k)))
                sel_q[k] <= acc_wdata;
        end
        assign sel_flat[k*DATA_W +: DATA_W] = sel_q[k];

        p_sel_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && acc_write && (acc_addr == ADDR_W'(SEL_BASE + k)))
            |=> (sel_q[k] == $past(acc_wdata)));

        p_sel_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !(acc_valid && acc_write && (acc_addr == ADDR_W'(SEL_BASE + k)))
            |=> $stable(sel_q[k]));
    end

    // readback mux: unmapped pointer values read zero
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < N_IN; k++) begin
            if (ptr_q == ADDR_W'(k)) rd_data = lvl_bits[k*DATA_W +: DATA_W];
        end
        for (int k = 0; k < N_SEL; k++) begin
            if (ptr_q == ADDR_W'(SEL_BASE + k)) rd_data = sel_q[k];
        end
    end

endmodule

// File: rtl/led_pin_cell.sv
module led_pin_cell
    import led_pin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       ext_n,
    output logic       lvl,
    output logic       chg
);

    pin_lvl_e state_q, state_d;
    logic     chg_q;

    // next-state: wired-AND of own drive and external pull
    always_comb begin
        state_d = state_q;
        unique case (sel_mode_e'(mode))
            SEL_DRIVE_LOW: state_d = LVL_LOW;
            SEL_RELEASE:   state_d = ext_n ? LVL_HIGH : LVL_LOW;
            SEL_BLINK_A,
            SEL_BLINK_B:   state_d = state_q;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LVL_HIGH;
        else state_q <= state_d;
    end

    // outputs: change strobe
    always_ff @(posedge clk) begin
        if (!rst_n) chg_q <= 1'b0;
        else chg_q <= (state_d != state_q);
    end

    assign lvl = state_q;
    assign chg = chg_q;

    p_drive_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (lvl == 1'b0));

    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (lvl == $past(ext_n)));

    p_blink_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode[1] |=> $stable(lvl));

    p_strobe_real_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chg |-> (lvl != $past(lvl)));

    p_strobe_seen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl != $past(lvl)) |-> chg);

endmodule

// File: rtl/led_pin_resolver.sv
module led_pin_resolver
    import led_pin_pkg::*;
#(
    parameter int NUM_PINS = 16,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [DATA_W-1:0]   acc_wdata,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [NUM_PINS-1:0] ext_n,
    output logic [NUM_PINS-1:0] lvl_out,
    output logic [NUM_PINS-1:0] chg_strb
);

    logic [2*NUM_PINS-1:0] sel_flat;

    led_sel_regs #(
        .NUM_PINS (NUM_PINS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .lvl_bits  (lvl_out),
        .sel_flat  (sel_flat),
        .rd_data   (rd_data)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        led_pin_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .mode  (sel_flat[2*i +: 2]),
            .ext_n (ext_n[i]),
            .lvl   (lvl_out[i]),
            .chg   (chg_strb[i])
        );
    end

endmodule

// File: tb/tb_led_pin_resolver.sv
module tb_led_pin_resolver;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_addr = 8'h00;
    logic [7:0]  acc_wdata = 8'h00;
    logic [7:0]  rd_data;
    logic [15:0] ext_n = 16'hFFFF;
    logic [15:0] lvl_out;
    logic [15:0] chg_strb;

    int checks = 0;
    int failures = 0;

    logic [7:0]  exp_sel [4];
    logic [15:0] exp_lvl;

    always #2.5 clk = ~clk;

    led_pin_resolver dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
        .ext_n(ext_n), .lvl_out(lvl_out), .chg_strb(chg_strb)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [7:0] a, input logic [7:0] d);
        acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic read_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        access(1'b0, a, 8'h00);
        chk(tag, 32'(rd_data), 32'(exp));
    endtask

    function automatic logic [15:0] model_lvl();
        logic [15:0] n = exp_lvl;
        for (int i = 0; i < 16; i++) begin
            logic [1:0] m = exp_sel[i/4][2*(i%4) +: 2];
            if (m == 2'b00) n[i] = 1'b0;
            else if (m == 2'b01) n[i] = ext_n[i];
        end
        return n;
    endfunction

    // one update edge, then compare levels and strobes
    task automatic settle_chk(input string tag);
        logic [15:0] old;
        @(posedge clk);
        @(negedge clk);
        old = exp_lvl;
        exp_lvl = model_lvl();
        chk({tag, " R6 lvl"}, 32'(lvl_out), 32'(exp_lvl));
        chk({tag, " R6 strobe"}, 32'(chg_strb), 32'(old ^ exp_lvl));
    endtask

    task automatic sel_write(input int k, input logic [7:0] d, input string tag);
        access(1'b1, 8'(4 + k), d);
        exp_sel[k] = d;
        chk({tag, " R7 no early level"}, 32'(lvl_out), 32'(exp_lvl));
        settle_chk(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) exp_sel[k] = 8'h55;
        exp_lvl = 16'hFFFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R9: reset state, pointer at unmapped 0xFF
        chk("R1 R9 rd_data after reset", 32'(rd_data), 32'h0);
        chk("R1 lvl_out", 32'(lvl_out), 32'hFFFF);
        chk("R1 chg_strb", 32'(chg_strb), 32'h0);
        for (int k = 0; k < 4; k++) read_chk("R1 selector reset", 8'(4 + k), 8'h55);
        read_chk("R1 level reg 0", 8'h00, 8'hFF);
        read_chk("R1 level reg 1", 8'h01, 8'hFF);

        // R4: known mappings
        sel_write(0, 8'h54, "R4 pin0");
        read_chk("R4 level reg 0 = FE", 8'h00, 8'hFE);
        sel_write(3, 8'h54, "R4 pin12");
        read_chk("R4 level reg 1 = EF", 8'h01, 8'hEF);
        sel_write(0, 8'h55, "R4 restore0");
        sel_write(3, 8'h55, "R4 restore3");
        sel_write(3, 8'h55, "R6 rewrite same");

        // R8: ignored writes and unmapped reads
        access(1'b1, 8'h00, 8'h00);
        read_chk("R8 write to level reg ignored", 8'h00, 8'hFF);
        access(1'b1, 8'h01, 8'h00);
        read_chk("R8 write to level reg 1 ignored", 8'h01, 8'hFF);
        access(1'b1, 8'h20, 8'h00);
        read_chk("R8 unmapped read", 8'h20, 8'h00);
        read_chk("R8 unmapped 0x02", 8'h02, 8'h00);
        for (int k = 0; k < 4; k++) read_chk("R8 selectors untouched", 8'(4 + k), 8'h55);
        chk("R8 levels untouched", 32'(lvl_out), 32'hFFFF);

        // sweep: every pin, both external values, all four codes
        for (int p = 0; p < 16; p++) begin
            for (int e = 1; e >= 0; e--) begin
                ext_n[p] = 1'(e);
                settle_chk("R3 ext change");
                for (int m = 0; m < 4; m++) begin
                    logic [7:0] b = 8'h55;
                    b[2*(p%4) +: 2] = 2'(m);
                    sel_write(p/4, b, (m == 0) ? "R2 drive low" :
                                      (m == 1) ? "R3 release" : "R5 blink hold");
                    read_chk("R4 level reg bit", 8'(p/8), exp_lvl[(p/8)*8 +: 8]);
                end
                ext_n[p] = ~ext_n[p];
                settle_chk("R5 ext toggle while blink");
                b_restore(p);
            end
        end

        // R2: external input ignored while driven low
        sel_write(1, 8'h54, "R2 pin4 low");
        ext_n[4] = 1'b0;
        settle_chk("R2 ext low on driven pin");
        ext_n[4] = 1'b1;
        settle_chk("R2 ext high on driven pin");
        sel_write(1, 8'h55, "R2 restore");

        // R9: pointer keeps naming the last accessed register
        read_chk("R9 pointer to selector 2", 8'h06, 8'h55);
        repeat (3) @(negedge clk);
        chk("R9 pointer held", 32'(rd_data), 32'h55);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic b_restore(input int p);
        ext_n[p] = 1'b1;
        settle_chk("R3 ext restore");
        sel_write(p/4, 8'h55, "R3 release restore");
    endtask

endmodule